// File: doc/BRIEF.md
# Locked Command Front End for a Small Nonvolatile Store

This block is the register-side front end of a small nonvolatile-memory controller. A bus master reaches it through a word-addressed register window. It fills a 32-byte staging buffer, writes a command word that names a target address, an operation and a byte count, and then watches a status word or two interrupt lines for completion. There are four operations. A data write copies the staging buffer into the store, and a data read fills the buffer from it. The other two are a single-byte read and a single-byte write of the store's own status byte.

The storage array is modelled inside the block as a byte memory. It is reached after a fixed start-up latency and then moves one byte per cycle. A write-once 31-bit key and a separate key-match register gate the block. While the lock is on and no matching key has been presented, commands are dropped and the staging buffer reads as zero.

The word index of each register is fixed: control 0, command 1, status 2, interrupt enable 3, key 4, key match 5, lock 6, and buffer words 8 to 15. Its byte offset is four times that index.

Top module: `nvm_cmd_front`

## Requirements
- R1: After reset every readable register and buffer word reads 0, the command word reads 0, and both interrupt lines and the debug-lock line are low.
- R2: Command code 1 copies buffer bytes 0..n-1 into the store at target address onward (address wraps at the store size), and code 0 copies them back into buffer bytes 0..n-1. Buffer byte i is bits 8*(i%4)+7:8*(i%4) of buffer word i/4. Buffer bytes at index n and above keep their value.
- R3: Size field (command bits 28:24) value 0 moves 32 bytes, and values 1 to 31 move that many bytes.
- R4: Command code 3 stores buffer byte 0 as the store's status byte. Code 2 loads that byte into buffer byte 0 and leaves bytes 1 to 31 unchanged.
- R5: Command codes 4 to 7 set the error flag (status bit 1), start no transfer and leave done (status bit 0) clear.
- R6: A command written while a transfer runs is rejected and sets the error flag. The running transfer still completes and sets done.
- R7: Status bit 8 reads 1 from the cycle after a command is accepted until the transfer ends, and done is then set and stays set.
- R8: Writing status with bit 0 or bit 1 at 1 clears that flag, and a 0 leaves it unchanged.
- R9: The done interrupt equals done AND enable bit 0, and the error interrupt equals error AND enable bit 1.
- R10: The key register keeps bits 30:0 of the first write after reset and ignores later writes. Writing bits 30:0 equal to the kept key into the match register unlocks the block until reset. Bit 31 is not compared.
- R11: While lock bit 1 is set and the block is not unlocked, command writes are ignored and buffer reads return 0.
- R12: With control bit 0 at 0, command writes are ignored.
- R13: Writing control with bit 1 at 1 aborts any transfer and clears done, error, busy and the whole buffer. Control bit 1 reads 0.
- R14: Lock bits 1:0 can be set but not cleared until reset, and lock bit 0 drives the debug-lock output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Word index into the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| bus_rvalid | output | 1 | Marks valid read data |
| irq_done | output | 1 | Done interrupt |
| irq_err | output | 1 | Error interrupt |
| dbg_lock | output | 1 | Debug-port lock request |

## Verification
The embedded properties check on every cycle that the interrupt lines follow flag AND enable, that a locked or inactive block never starts a transfer, that a command rejected while busy raises error, and that each finish raises done. They also check that every transfer runs for exactly the byte count its size code implies, that the key and the lock bits never change once set, and that a soft reset empties the buffer. Only the bench scenarios show what the data path does: bytes that land at the right store addresses and come back into the right buffer lanes, untouched lanes beyond the count, and the status-byte round trip. The scenarios also cover the key being kept from the first write only and not a later one, and the buffer reappearing after unlock.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  localparam int BUF_BYTES = 32;
  localparam int BUF_WORDS = BUF_BYTES / 4;
  localparam int IDX_W     = $clog2(BUF_BYTES);
  localparam int WIDX_W    = $clog2(BUF_WORDS);
  localparam int REG_AW    = WIDX_W + 1;

  localparam logic [REG_AW-1:0] A_CTRL = REG_AW'(0);
  localparam logic [REG_AW-1:0] A_CMD  = REG_AW'(1);
  localparam logic [REG_AW-1:0] A_STS  = REG_AW'(2);
  localparam logic [REG_AW-1:0] A_IEN  = REG_AW'(3);
  localparam logic [REG_AW-1:0] A_KEY  = REG_AW'(4);
  localparam logic [REG_AW-1:0] A_MTCH = REG_AW'(5);
  localparam logic [REG_AW-1:0] A_LOCK = REG_AW'(6);

  localparam logic [2:0] OP_RD   = 3'd0;
  localparam logic [2:0] OP_WR   = 3'd1;
  localparam logic [2:0] OP_SRD  = 3'd2;
  localparam logic [2:0] OP_SWR  = 3'd3;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_XFER, S_TAIL} eng_state_t;
endpackage

// File: rtl/nvm_key_lock.sv
module nvm_key_lock (
  input  logic        clk,
  input  logic        rst,
  input  logic        key_we,
  input  logic        match_we,
  input  logic        lock_we,
  input  logic [30:0] key_in,
  input  logic [1:0]  lock_in,
  output logic        locked,
  output logic [1:0]  lock_bits
);
  logic [30:0] key_q;
  logic        key_set_q;
  logic        open_q;
  logic [1:0]  lock_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      key_q     <= '0;
      key_set_q <= 1'b0;
      open_q    <= 1'b0;
      lock_q    <= '0;
    end else begin
      if (key_we && !key_set_q) begin
        key_q     <= key_in;
        key_set_q <= 1'b1;
      end
      if (match_we && key_set_q && (key_in == key_q))
        open_q <= 1'b1;
      if (lock_we)
        lock_q <= lock_q | lock_in;
    end
  end

  assign locked    = lock_q[1] && !open_q;
  assign lock_bits = lock_q;

  assert_key_once_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(key_set_q) && key_set_q) |-> $stable(key_q));

  assert_lock_sticky_R14: assert property (@(posedge clk) disable iff (rst)
    $past(lock_q[1]) |-> lock_q[1]);
endmodule

// File: rtl/nvm_data_buf.sv
module nvm_data_buf #(
  parameter int BUF_BYTES = 32,
  parameter int IDX_W     = $clog2(BUF_BYTES),
  parameter int WIDX_W    = $clog2(BUF_BYTES / 4)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              bus_we,
  input  logic [WIDX_W-1:0] bus_widx,
  input  logic [31:0]       bus_wdata,
  input  logic [WIDX_W-1:0] bus_ridx,
  output logic [31:0]       bus_rword,
  input  logic [IDX_W-1:0]  eng_ridx,
  output logic [7:0]        eng_rbyte,
  input  logic              eng_we,
  input  logic [IDX_W-1:0]  eng_widx,
  input  logic [7:0]        eng_wbyte
);
  logic [7:0] bq [BUF_BYTES];

  for (genvar b = 0; b < BUF_BYTES; b++) begin : g_byte
    localparam int WRD  = b / 4;
    localparam int LANE = b % 4;
    always_ff @(posedge clk) begin
      if (rst || clr)
        bq[b] <= '0;
      else if (eng_we && eng_widx == IDX_W'(b))
        bq[b] <= eng_wbyte;
      else if (bus_we && bus_widx == WIDX_W'(WRD))
        bq[b] <= bus_wdata[8*LANE +: 8];
    end
  end

  always_comb begin
    for (int j = 0; j < 4; j++)
      bus_rword[8*j +: 8] = bq[{bus_ridx, 2'(j)}];
  end

  assign eng_rbyte = bq[eng_ridx];

  assert_clear_R13: assert property (@(posedge clk) disable iff (rst)
    clr |=> (bq[0] == 8'h00 && bq[BUF_BYTES-1] == 8'h00));
endmodule

// File: rtl/nvm_xfer_engine.sv
module nvm_xfer_engine
  import nvm_pkg::*;
#(
  parameter int ARRAY_BYTES = 256,
  parameter int LATENCY     = 4,
  parameter int AW          = $clog2(ARRAY_BYTES),
  parameter int LAT_W       = $clog2(LATENCY + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             srst,
  input  logic             start,
  input  logic [2:0]       op,
  input  logic [IDX_W-1:0] size,
  input  logic [AW-1:0]    taddr,
  output logic [IDX_W-1:0] buf_ridx,
  input  logic [7:0]       buf_rbyte,
  output logic             buf_we,
  output logic [IDX_W-1:0] buf_widx,
  output logic [7:0]       buf_wbyte,
  output logic             busy,
  output logic             fin
);
  eng_state_t       st_q;
  logic [LAT_W-1:0] lat_q;
  logic [IDX_W-1:0] idx_q, last_q, pend_idx_q;
  logic [2:0]       op_q;
  logic [AW-1:0]    base_q, mem_addr;
  logic [7:0]       sts_byte_q, mem_rd_q;
  logic             pend_q, fin_q, in_xfer, mem_we;
  logic [7:0]       mem [ARRAY_BYTES];

  assign in_xfer  = (st_q == S_XFER) && !srst;
  assign mem_addr = base_q + AW'(idx_q);
  assign mem_we   = in_xfer && (op_q == OP_WR);
  assign buf_ridx = idx_q;

  always_ff @(posedge clk) begin
    if (mem_we)
      mem[mem_addr] <= buf_rbyte;
    mem_rd_q <= mem[mem_addr];
  end

  always_ff @(posedge clk) begin
    if (rst || srst) begin
      st_q       <= S_IDLE;
      lat_q      <= '0;
      idx_q      <= '0;
      last_q     <= '0;
      op_q       <= OP_RD;
      base_q     <= '0;
      pend_q     <= 1'b0;
      pend_idx_q <= '0;
      fin_q      <= 1'b0;
    end else begin
      pend_q     <= in_xfer && (op_q == OP_RD);
      pend_idx_q <= idx_q;
      fin_q      <= (st_q == S_TAIL);
      case (st_q)
        S_IDLE: if (start) begin
          st_q   <= S_WAIT;
          lat_q  <= '0;
          idx_q  <= '0;
          op_q   <= op;
          base_q <= taddr;
          last_q <= (op == OP_SRD || op == OP_SWR) ? '0 : size - 1'b1;
        end
        S_WAIT: begin
          if (lat_q == LAT_W'(LATENCY - 1)) st_q <= S_XFER;
          else lat_q <= lat_q + 1'b1;
        end
        S_XFER: begin
          if (idx_q == last_q) st_q <= S_TAIL;
          else idx_q <= idx_q + 1'b1;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      sts_byte_q <= '0;
    else if (in_xfer && op_q == OP_SWR)
      sts_byte_q <= buf_rbyte;
  end

  always_comb begin
    buf_we    = 1'b0;
    buf_widx  = pend_idx_q;
    buf_wbyte = mem_rd_q;
    if (pend_q && !srst) begin
      buf_we = 1'b1;
    end else if (in_xfer && op_q == OP_SRD) begin
      buf_we    = 1'b1;
      buf_widx  = '0;
      buf_wbyte = sts_byte_q;
    end
  end

  assign busy = (st_q != S_IDLE);
  assign fin  = fin_q;

  // Checker: counts transfer cycles and compares with the size code.
  logic [IDX_W:0] chk_cnt, chk_exp;
  always_ff @(posedge clk) begin
    if (rst) begin
      chk_cnt <= '0;
      chk_exp <= '0;
    end else if (st_q == S_IDLE && start) begin
      chk_cnt <= '0;
      chk_exp <= (op == OP_SRD || op == OP_SWR) ? (IDX_W+1)'(1) :
                 (size == '0) ? (IDX_W+1)'(BUF_BYTES) : {1'b0, size};
    end else if (st_q == S_XFER) begin
      chk_cnt <= chk_cnt + 1'b1;
    end
  end

  assert_len_R3: assert property (@(posedge clk) disable iff (rst || srst)
    (st_q == S_TAIL) |-> (chk_cnt == chk_exp));
endmodule

// File: rtl/nvm_cmd_front.sv
module nvm_cmd_front
  import nvm_pkg::*;
#(
  parameter int ARRAY_BYTES = 256,
  parameter int LATENCY     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              irq_done,
  output logic              irq_err,
  output logic              dbg_lock
);
  localparam int AW = $clog2(ARRAY_BYTES);

  logic        act_q, done_q, err_q, irq_done_q, irq_err_q, rvalid_q;
  logic [1:0]  ien_q, lock_bits, ien_n;
  logic [15:0] cmd_addr_q;
  logic [2:0]  cmd_op_q;
  logic [IDX_W-1:0] cmd_sz_q;
  logic [31:0] rdata_q, buf_word;
  logic        locked, busy, fin, srst, done_n, err_n;
  logic        cmd_wr, cmd_ok, op_bad, launch, data_wr, sts_wr;
  logic [IDX_W-1:0] e_ridx, e_widx;
  logic [7:0]  e_rbyte, e_wbyte;
  logic        e_we;

  assign srst    = bus_wr && bus_addr == A_CTRL && bus_wdata[1];
  assign cmd_wr  = bus_wr && bus_addr == A_CMD;
  assign sts_wr  = bus_wr && bus_addr == A_STS;
  assign data_wr = bus_wr && bus_addr[REG_AW-1];
  assign cmd_ok  = cmd_wr && act_q && !locked;
  assign op_bad  = bus_wdata[18] != 1'b0;
  assign launch  = cmd_ok && !busy && !op_bad;

  nvm_key_lock u_lock (
    .clk(clk), .rst(rst),
    .key_we(bus_wr && bus_addr == A_KEY),
    .match_we(bus_wr && bus_addr == A_MTCH),
    .lock_we(bus_wr && bus_addr == A_LOCK),
    .key_in(bus_wdata[30:0]), .lock_in(bus_wdata[1:0]),
    .locked(locked), .lock_bits(lock_bits)
  );

  nvm_data_buf #(.BUF_BYTES(BUF_BYTES)) u_buf (
    .clk(clk), .rst(rst), .clr(srst),
    .bus_we(data_wr), .bus_widx(bus_addr[WIDX_W-1:0]), .bus_wdata(bus_wdata),
    .bus_ridx(bus_addr[WIDX_W-1:0]), .bus_rword(buf_word),
    .eng_ridx(e_ridx), .eng_rbyte(e_rbyte),
    .eng_we(e_we), .eng_widx(e_widx), .eng_wbyte(e_wbyte)
  );

  nvm_xfer_engine #(.ARRAY_BYTES(ARRAY_BYTES), .LATENCY(LATENCY)) u_eng (
    .clk(clk), .rst(rst), .srst(srst), .start(launch),
    .op(bus_wdata[18:16]), .size(bus_wdata[24 +: IDX_W]), .taddr(bus_wdata[AW-1:0]),
    .buf_ridx(e_ridx), .buf_rbyte(e_rbyte),
    .buf_we(e_we), .buf_widx(e_widx), .buf_wbyte(e_wbyte),
    .busy(busy), .fin(fin)
  );

  always_comb begin
    ien_n  = (bus_wr && bus_addr == A_IEN) ? bus_wdata[1:0] : ien_q;
    done_n = (done_q && !(sts_wr && bus_wdata[0])) || fin;
    err_n  = (err_q && !(sts_wr && bus_wdata[1])) || (cmd_ok && (busy || op_bad));
    if (srst) begin
      done_n = 1'b0;
      err_n  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q      <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      ien_q      <= '0;
      irq_done_q <= 1'b0;
      irq_err_q  <= 1'b0;
      cmd_addr_q <= '0;
      cmd_op_q   <= '0;
      cmd_sz_q   <= '0;
    end else begin
      if (bus_wr && bus_addr == A_CTRL) act_q <= bus_wdata[0];
      done_q     <= done_n;
      err_q      <= err_n;
      ien_q      <= ien_n;
      irq_done_q <= done_n && ien_n[0];
      irq_err_q  <= err_n && ien_n[1];
      if (cmd_ok && !busy) begin
        cmd_addr_q <= bus_wdata[15:0];
        cmd_op_q   <= bus_wdata[18:16];
        cmd_sz_q   <= bus_wdata[24 +: IDX_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= bus_rd;
      if (bus_rd) begin
        rdata_q <= '0;
        if (bus_addr[REG_AW-1])
          rdata_q <= locked ? '0 : buf_word;
        else case (bus_addr)
          A_CTRL: rdata_q <= {31'b0, act_q};
          A_CMD:  rdata_q <= {3'b0, cmd_sz_q, 5'b0, cmd_op_q, cmd_addr_q};
          A_STS:  rdata_q <= {23'b0, busy, 6'b0, err_q, done_q};
          A_IEN:  rdata_q <= {30'b0, ien_q};
          A_LOCK: rdata_q <= {30'b0, lock_bits};
          default: rdata_q <= '0;
        endcase
      end
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
  assign irq_done   = irq_done_q;
  assign irq_err    = irq_err_q;
  assign dbg_lock   = lock_bits[0];

  assert_irq_done_R9: assert property (@(posedge clk) disable iff (rst)
    irq_done == (done_q && ien_q[0]));
  assert_irq_err_R9: assert property (@(posedge clk) disable iff (rst)
    irq_err == (err_q && ien_q[1]));
  assert_locked_idle_R11: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && locked && !busy) |=> !busy);
  assert_inactive_idle_R12: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !act_q && !busy) |=> !busy);
  assert_busy_reject_R6: assert property (@(posedge clk) disable iff (rst || srst)
    (cmd_ok && busy) |=> err_q);
  assert_fin_done_R7: assert property (@(posedge clk) disable iff (rst || srst)
    fin |=> done_q);
endmodule

// File: tb/nvm_cmd_front_bench.sv
module nvm_cmd_front_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, irq_done, irq_err, dbg_lock;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  nvm_cmd_front u_nvm_cmd_front (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .irq_done(irq_done), .irq_err(irq_err), .dbg_lock(dbg_lock)
  );

  // Monitor: pops expected read data as the design returns it.
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL unexpected read data: actual=%h expected=none", bus_rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          bad++;
          $display("FAIL %s: actual=%h expected=%h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] e, input string t);
    total++;
    if (act !== e) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", t, act, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] cmd(input logic [2:0] op, input logic [4:0] sz,
                                      input logic [15:0] ad);
    return {3'b0, sz, 5'b0, op, ad};
  endfunction

  function automatic logic [7:0] pb(input logic [7:0] seed, input int i);
    return seed + 8'(i * 7);
  endfunction

  function automatic logic [31:0] pw(input logic [7:0] seed, input int k);
    return {pb(seed, 4*k+3), pb(seed, 4*k+2), pb(seed, 4*k+1), pb(seed, 4*k)};
  endfunction

  task automatic zero_buf();
    for (int k = 0; k < 8; k++) wr(4'(8 + k), 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    rd(4'd0, 32'h0, "R1 ctrl");
    rd(4'd1, 32'h0, "R1 cmd");
    rd(4'd2, 32'h0, "R1 status");
    rd(4'd3, 32'h0, "R1 ien");
    rd(4'd6, 32'h0, "R1 lock");
    rd(4'd8, 32'h0, "R1 buf");
    chk({29'b0, irq_done, irq_err, dbg_lock}, 32'h0, "R1 irq/dbg lines");

    // R12: inactive control ignores commands
    wr(4'd1, cmd(3'd1, 5'd4, 16'h0));
    rd(4'd2, 32'h0, "R12 no busy");
    idle(50);
    rd(4'd2, 32'h0, "R12 no done");

    // R2/R7: write 5 bytes then read them back
    wr(4'd0, 32'h1);
    for (int k = 0; k < 8; k++) wr(4'(8 + k), pw(8'h30, k));
    wr(4'd1, cmd(3'd1, 5'd5, 16'h0010));
    rd(4'd2, 32'h100, "R7 busy after accept");
    idle(50);
    rd(4'd2, 32'h1, "R7 done set");
    rd(4'd2, 32'h1, "R7 done sticky");
    rd(4'd1, cmd(3'd1, 5'd5, 16'h0010), "R2 command readback");
    // R9: done interrupt follows enable
    wr(4'd3, 32'h1);
    chk({31'b0, irq_done}, 32'h1, "R9 irq_done on");
    wr(4'd2, 32'h1);
    rd(4'd2, 32'h0, "R8 done cleared");
    chk({31'b0, irq_done}, 32'h0, "R9 irq_done off");
    zero_buf();
    wr(4'd1, cmd(3'd0, 5'd5, 16'h0010));
    idle(50);
    rd(4'd8, pw(8'h30, 0), "R2 read bytes 0-3");
    rd(4'd9, {24'h0, pb(8'h30, 4)}, "R2 read byte 4, upper lanes kept");
    rd(4'd10, 32'h0, "R2 untouched word");
    wr(4'd2, 32'h3);

    // R3: size code 0 moves 32 bytes, wrapping past the store end
    for (int k = 0; k < 8; k++) wr(4'(8 + k), pw(8'h91, k));
    wr(4'd1, cmd(3'd1, 5'd0, 16'h00F0));
    idle(50);
    zero_buf();
    wr(4'd1, cmd(3'd0, 5'd0, 16'h00F0));
    idle(50);
    for (int k = 0; k < 8; k++) rd(4'(8 + k), pw(8'h91, k), "R3 full buffer");
    wr(4'd2, 32'h3);

    // R4: status byte write then read
    wr(4'd8, 32'h0000005A);
    wr(4'd1, cmd(3'd3, 5'd1, 16'h0));
    idle(50);
    wr(4'd8, 32'hFFFFFFFF);
    wr(4'd1, cmd(3'd2, 5'd1, 16'h0));
    idle(50);
    rd(4'd8, 32'hFFFFFF5A, "R4 status byte in lane 0");
    rd(4'd9, pw(8'h91, 1), "R4 other bytes kept");
    wr(4'd2, 32'h3);

    // R5: bad command code, with error interrupt
    wr(4'd3, 32'h2);
    wr(4'd1, cmd(3'd5, 5'd1, 16'h0));
    rd(4'd2, 32'h2, "R5 error, no busy");
    chk({31'b0, irq_err}, 32'h1, "R9 irq_err on");
    idle(50);
    rd(4'd2, 32'h2, "R5 no done");
    wr(4'd2, 32'h1);
    rd(4'd2, 32'h2, "R8 zero bit leaves error");
    wr(4'd2, 32'h2);
    rd(4'd2, 32'h0, "R8 error cleared");
    chk({31'b0, irq_err}, 32'h0, "R9 irq_err off");

    // R6: second command while busy
    wr(4'd1, cmd(3'd1, 5'd8, 16'h0020));
    wr(4'd1, cmd(3'd0, 5'd2, 16'h0040));
    rd(4'd2, 32'h102, "R6 rejected while busy");
    idle(50);
    rd(4'd2, 32'h3, "R6 first completes");
    rd(4'd1, cmd(3'd1, 5'd8, 16'h0020), "R6 command kept");
    wr(4'd2, 32'h3);

    // R13: soft reset aborts
    wr(4'd1, cmd(3'd1, 5'd0, 16'h0));
    wr(4'd0, 32'h3);
    rd(4'd2, 32'h0, "R13 status cleared");
    rd(4'd8, 32'h0, "R13 buffer cleared");
    rd(4'd0, 32'h1, "R13 bit reads zero");
    idle(50);
    rd(4'd2, 32'h0, "R13 no late done");

    // R10/R11/R14: key and lock
    wr(4'd4, 32'h12345678);
    wr(4'd4, 32'h00000000);
    wr(4'd6, 32'h3);
    rd(4'd6, 32'h3, "R14 lock bits");
    chk({31'b0, dbg_lock}, 32'h1, "R14 debug lock line");
    wr(4'd8, 32'hCAFE0001);
    rd(4'd8, 32'h0, "R11 buffer hidden");
    wr(4'd1, cmd(3'd1, 5'd1, 16'h0));
    rd(4'd2, 32'h0, "R11 command ignored");
    idle(50);
    rd(4'd2, 32'h0, "R11 no done");
    wr(4'd5, 32'h00000000);
    rd(4'd8, 32'h0, "R10 later key write ignored");
    wr(4'd5, 32'h92345678);
    rd(4'd8, 32'hCAFE0001, "R10 unlocked, bit31 ignored");
    wr(4'd6, 32'h0);
    rd(4'd6, 32'h3, "R14 lock not clearable");

    idle(4);
    chk(32'(exp_q.size()), 32'h0, "scoreboard drained");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule